// File: doc/BRIEF.md
# Pipelined Parallel-Prefix Adder

This block adds two unsigned operands of parameterised width and returns the full sum plus a carry-out bit. It uses a Kogge-Stone carry network. Every logic level is a register stage, so the block accepts a new operand pair on every clock and returns each result a fixed number of cycles later. A valid flag travels with each operand pair through the pipeline. When `in_valid` is low, the slot in the pipeline is empty and comes out as a cycle with `out_valid` low.

The pipeline has three kinds of stage. The first stage forms the per-bit generate and propagate terms. Then comes one stage for each prefix level. At prefix level k, each bit position merges its group terms with those of the position 2^k below it. Positions below 2^k simply hold their terms for one cycle. The per-bit propagate values are delayed alongside the prefix levels, so the last stage can form the sum bits from them and the finished carries.

Top module: `ksa_pipe_adder`

## Requirements
- R1: The first stage registers a generate term and a propagate term for every bit i. The generate term is a_i AND b_i and the propagate term is a_i XOR b_i, so at most one of the two is set for any bit.
- R2: Each prefix level combines a higher group (G_h, P_h) with the group directly below it (G_l, P_l). The result is G = G_h OR (P_h AND G_l) and P = P_h AND P_l. Whenever a group's P is set, that group's G is clear.
- R3: `out_sum` equals in_a + in_b with no truncation. Bit i for i < WIDTH is the propagate of bit i XOR the carry from the bits below it. Bit WIDTH is the group generate over all bits.
- R4: The latency from an accepted input to its result is 2 + ceil(log2 WIDTH) cycles. That is 5 cycles for WIDTH = 8 and 6 cycles for WIDTH = 16.
- R5: A new operand pair is accepted every cycle. Back-to-back inputs produce back-to-back correct results in the same order.
- R6: `out_valid` reproduces the pattern of `in_valid`, including gaps, delayed by exactly the latency of R4.
- R7: A low `rst_n` sampled at a clock edge clears `out_valid` and `out_sum` to zero. Inputs already in flight are lost.
- R8: WIDTH is a parameter. The block gives correct results for both WIDTH = 8 and WIDTH = 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every stage updates on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the operand pair on in_a and in_b as valid |
| in_a | input | WIDTH | First unsigned operand |
| in_b | input | WIDTH | Second unsigned operand |
| out_valid | output | 1 | Marks out_sum as holding a result |
| out_sum | output | WIDTH+1 | Sum, with the carry-out in the top bit |

## Verification
The bench drives a WIDTH = 8 instance and a WIDTH = 16 instance side by side and compares both with a reference adder delayed by the expected latency.

Operand patterns are chosen so that each one exposes a different fault:
- All-ones plus all-ones, and all-ones plus one, need a carry across the full width. A wrong combine term at any prefix level, or a wrong pass-through, shows up in these results.
- Alternating-bit operands leave long runs of propagate with no generate. They catch a prefix level that merges with the wrong distance.
- Zero plus zero confirms that nothing is generated from empty inputs.
- Long random runs with no gaps check that consecutive results do not mix.

A single isolated pulse measures the latency exactly. Gapped valid patterns and a reset in the middle of a busy stream check how the valid flag is carried and that reset clears the pipeline.

// File: rtl/ksa_pkg.sv
// Shared helpers for the pipelined prefix adder.
// Assumes the operand width is at least 2.
package ksa_pkg;
    // Number of prefix levels needed to cover the operand width.
    function automatic int ksa_levels(input int width);
        return (width < 2) ? 1 : $clog2(width);
    endfunction

    // Total pipeline depth: the generate/propagate stage, the prefix levels and the sum stage.
    function automatic int ksa_latency(input int width);
        return ksa_levels(width) + 2;
    endfunction
endpackage

// File: rtl/ksa_gp_row.sv
// First pipeline stage: registers the per-bit generate and propagate terms
// together with the valid flag. Assumes rst_n is synchronous and active low.
module ksa_gp_row #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             v_o,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] p_o
);
    // Register the bitwise generate and propagate terms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            g_o <= '0;
            p_o <= '0;
        end else begin
            v_o <= v_i;
            g_o <= a_i & b_i;
            p_o <= a_i ^ b_i;
        end
    end

    // No bit may be both generate and propagate.
    assert_gp_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (g_o & p_o) == '0);

    // The valid flag moves forward exactly one stage per cycle.
    assert_gp_valid_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (v_o == $past(v_i)));
endmodule

// File: rtl/ksa_prefix_level.sv
// One registered Kogge-Stone prefix level. A position at or above DIST merges
// its group terms with those of the position DIST below it. Positions below
// DIST hold their terms for one cycle. The per-bit propagate values and the
// valid flag are delayed by one stage. Assumes 1 <= DIST < WIDTH.
module ksa_prefix_level #(
    parameter int WIDTH = 16,
    parameter int DIST  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic [WIDTH-1:0] g_i,
    input  logic [WIDTH-1:0] pg_i,
    input  logic [WIDTH-1:0] pb_i,
    output logic             v_o,
    output logic [WIDTH-1:0] g_o,
    output logic [WIDTH-1:0] pg_o,
    output logic [WIDTH-1:0] pb_o
);
    logic [WIDTH-1:0] g_nx;
    logic [WIDTH-1:0] pg_nx;

    // Choose, per bit position, between merging groups and holding the terms.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i >= DIST) begin : g_merge
            assign g_nx[i]  = g_i[i] | (pg_i[i] & g_i[i-DIST]);
            assign pg_nx[i] = pg_i[i] & pg_i[i-DIST];
        end else begin : g_hold
            assign g_nx[i]  = g_i[i];
            assign pg_nx[i] = pg_i[i];
        end
    end

    // Register the merged group terms and delay the per-bit propagates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o  <= 1'b0;
            g_o  <= '0;
            pg_o <= '0;
            pb_o <= '0;
        end else begin
            v_o  <= v_i;
            g_o  <= g_nx;
            pg_o <= pg_nx;
            pb_o <= pb_i;
        end
    end

    // A group that propagates everywhere can never also generate.
    assert_group_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (g_o & pg_o) == '0);

    // The valid flag moves forward exactly one stage per cycle.
    assert_level_valid_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (v_o == $past(v_i)));
endmodule

// File: rtl/ksa_sum_row.sv
// Final stage: forms the sum bits from the delayed per-bit propagates and the
// finished carries, and registers them. Assumes g_i[i] is the group generate
// over bits i down to 0.
module ksa_sum_row #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic [WIDTH-1:0] g_i,
    input  logic [WIDTH-1:0] pb_i,
    output logic             v_o,
    output logic [WIDTH:0]   sum_o
);
    logic [WIDTH:0] carry;

    // The carry into bit 0 is zero; the carry into bit i+1 is the prefix generate at bit i.
    assign carry = {g_i, 1'b0};

    // Register the sum bits together with the carry-out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_o   <= 1'b0;
            sum_o <= '0;
        end else begin
            v_o   <= v_i;
            sum_o <= {carry[WIDTH], pb_i ^ carry[WIDTH-1:0]};
        end
    end

    // The valid flag moves forward exactly one stage per cycle.
    assert_sum_valid_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (v_o == $past(v_i)));
endmodule

// File: rtl/ksa_pipe_adder.sv
// Top level of the pipelined Kogge-Stone adder. It chains the
// generate/propagate stage, ceil(log2 WIDTH) prefix levels and the sum stage.
// It accepts one operand pair per cycle. Assumes WIDTH >= 2 and a synchronous
// active-low reset.
module ksa_pipe_adder
    import ksa_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_a,
    input  logic [WIDTH-1:0] in_b,
    output logic             out_valid,
    output logic [WIDTH:0]   out_sum
);
    localparam int LEVELS = ksa_levels(WIDTH);

    // Signals between stages; index k is the input to prefix level k.
    logic             v_s  [0:LEVELS];
    logic [WIDTH-1:0] g_s  [0:LEVELS];
    logic [WIDTH-1:0] pg_s [0:LEVELS];
    logic [WIDTH-1:0] pb_s [0:LEVELS];

    ksa_gp_row #(.WIDTH(WIDTH)) u_gp (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (in_valid),
        .a_i   (in_a),
        .b_i   (in_b),
        .v_o   (v_s[0]),
        .g_o   (g_s[0]),
        .p_o   (pg_s[0])
    );

    // At the first level the group propagate and the bit propagate are the same.
    assign pb_s[0] = pg_s[0];

    // One registered level for each doubling of the merge distance.
    for (genvar k = 0; k < LEVELS; k++) begin : g_level
        ksa_prefix_level #(.WIDTH(WIDTH), .DIST(1 << k)) u_lvl (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (v_s[k]),
            .g_i   (g_s[k]),
            .pg_i  (pg_s[k]),
            .pb_i  (pb_s[k]),
            .v_o   (v_s[k+1]),
            .g_o   (g_s[k+1]),
            .pg_o  (pg_s[k+1]),
            .pb_o  (pb_s[k+1])
        );
    end

    ksa_sum_row #(.WIDTH(WIDTH)) u_sum (
        .clk   (clk),
        .rst_n (rst_n),
        .v_i   (v_s[LEVELS]),
        .g_i   (g_s[LEVELS]),
        .pb_i  (pb_s[LEVELS]),
        .v_o   (out_valid),
        .sum_o (out_sum)
    );

    // The carry-out bit must agree with the final group generate one cycle earlier.
    assert_carry_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_sum[WIDTH] == $past(g_s[LEVELS][WIDTH-1])));

    // One cycle after reset is sampled, the output is clear.
    assert_reset_clear_R7: assert property (@(posedge clk)
        $past(!rst_n) |-> (!out_valid && out_sum == '0));
endmodule

// File: tb/ksa_pipe_adder_tb.sv
// Directed bench: runs a 16-bit and an 8-bit instance side by side against delayed reference sums.
module ksa_pipe_adder_tb;
    localparam int W16 = 16;
    localparam int W8  = 8;
    localparam int L16 = 2 + $clog2(W16);
    localparam int L8  = 2 + $clog2(W8);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [W16-1:0]  a16 = '0, b16 = '0;
    logic [W8-1:0]   a8 = '0, b8 = '0;
    logic            ov16, ov8;
    logic [W16:0]    os16;
    logic [W8:0]     os8;

    int    n_chk = 0;
    int    n_err = 0;
    logic  mon_en = 1'b0;
    string cur_req = "R5";

    always #5 clk = ~clk;

    ksa_pipe_adder #(.WIDTH(W16)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(a16), .in_b(b16),
        .out_valid(ov16), .out_sum(os16)
    );

    ksa_pipe_adder #(.WIDTH(W8)) u_dut8 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(a8), .in_b(b8),
        .out_valid(ov8), .out_sum(os8)
    );

    // Reference pipelines: the valid flag and the true sum, delayed by the expected latency.
    logic         mv16 [L16];
    logic [W16:0] ms16 [L16];
    logic         mv8  [L8];
    logic [W8:0]  ms8  [L8];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < L16; j++) begin mv16[j] <= 1'b0; ms16[j] <= '0; end
            for (int j = 0; j < L8; j++)  begin mv8[j]  <= 1'b0; ms8[j]  <= '0; end
        end else begin
            mv16[0] <= in_valid; ms16[0] <= {1'b0, a16} + {1'b0, b16};
            mv8[0]  <= in_valid; ms8[0]  <= {1'b0, a8} + {1'b0, b8};
            for (int j = 1; j < L16; j++) begin mv16[j] <= mv16[j-1]; ms16[j] <= ms16[j-1]; end
            for (int j = 1; j < L8; j++)  begin mv8[j]  <= mv8[j-1];  ms8[j]  <= ms8[j-1];  end
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare both instances with the reference on every falling edge.
    always @(negedge clk) begin
        if (mon_en && rst_n) begin
            chk(cur_req, "valid16", 32'(ov16), 32'(mv16[L16-1]));
            chk(cur_req, "valid8",  32'(ov8),  32'(mv8[L8-1]));
            if (mv16[L16-1]) chk(cur_req, "sum16 (R8)", 32'(os16), 32'(ms16[L16-1]));
            if (mv8[L8-1])   chk(cur_req, "sum8 (R8)",  32'(os8),  32'(ms8[L8-1]));
        end
    end

    // Apply one operand pair on the falling edge; the 8-bit instance gets its own bytes.
    task automatic drive(input logic v, input logic [W16-1:0] a, input logic [W16-1:0] b);
        @(negedge clk);
        in_valid = v;
        a16 = a; b16 = b;
        a8 = a[7:0]; b8 = b[15:8];
    endtask

    task automatic drain();
        for (int i = 0; i < L16 + 2; i++) drive(1'b0, '0, '0);
    endtask

    // R7: reset clears both outputs.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7", "valid16 in reset", 32'(ov16), 32'd0);
        chk("R7", "sum16 in reset", 32'(os16), 32'd0);
        chk("R7", "valid8 in reset", 32'(ov8), 32'd0);
        chk("R7", "sum8 in reset", 32'(os8), 32'd0);
        rst_n = 1'b1;
        mon_en = 1'b1;
    endtask

    // R1, R2, R3: operands that carry across the full width, alternating patterns and zeros.
    task automatic t_boundary();
        cur_req = "R3";
        drive(1'b1, 16'hFFFF, 16'hFFFF);
        drive(1'b1, 16'hFFFF, 16'h0001);
        drive(1'b1, 16'h0000, 16'h0000);
        drive(1'b1, 16'hAAAA, 16'h5555);
        drive(1'b1, 16'h5555, 16'h5555);
        drive(1'b1, 16'h8000, 16'h8000);
        drive(1'b1, 16'h01FF, 16'hFF01);
        drive(1'b1, 16'h7FFF, 16'h0001);
        drain();
    endtask

    // R4: an isolated pulse emerges after exactly the expected number of cycles.
    task automatic t_latency();
        int c16 = 0;
        int c8  = 0;
        cur_req = "R4";
        drive(1'b1, 16'h1234, 16'h4321);
        drive(1'b0, '0, '0);
        for (int c = 2; c <= 12; c++) begin
            if (ov16 && c16 == 0) c16 = c - 1;
            if (ov8 && c8 == 0)   c8  = c - 1;
            @(negedge clk);
        end
        chk("R4", "latency16", 32'(c16), 32'(L16));
        chk("R4", "latency8",  32'(c8),  32'(L8));
    endtask

    // R5: a long back-to-back stream of random operands.
    task automatic t_stream();
        cur_req = "R5";
        for (int i = 0; i < 300; i++) drive(1'b1, 16'($urandom), 16'($urandom));
        drain();
    endtask

    // R6: gaps in in_valid reappear unchanged at the output.
    task automatic t_gaps();
        cur_req = "R6";
        for (int i = 0; i < 120; i++) drive(1'(($urandom % 3) != 0), 16'($urandom), 16'($urandom));
        for (int i = 0; i < 20; i++)  drive(1'(i % 2), 16'hFFFF - 16'(i), 16'(i));
        drain();
    endtask

    // R7: a reset while the pipeline is full discards everything in flight.
    task automatic t_mid_reset();
        cur_req = "R7";
        for (int i = 0; i < 4; i++) drive(1'b1, 16'($urandom), 16'($urandom));
        rst_n = 1'b0;
        @(negedge clk);
        chk("R7", "valid16 after mid reset", 32'(ov16), 32'd0);
        chk("R7", "valid8 after mid reset",  32'(ov8),  32'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < L16 + 1; i++) begin
            @(negedge clk);
            chk("R7", "no stale valid16", 32'(ov16), 32'd0);
            chk("R7", "no stale valid8",  32'(ov8),  32'd0);
        end
    endtask

    initial begin
        t_reset();
        t_boundary();
        t_latency();
        t_stream();
        t_gaps();
        t_mid_reset();
        drain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure and still reaches the summary.
    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule